// File: doc/BRIEF.md
# Pixel Clock PLL Reprogramming Sequencer

This controller applies a new set of divider values to a pixel-clock PLL without letting a glitching clock reach the display pipe. It owns a 64-bit PLL control word. When it gets a start pulse it takes the reference divider, the feedback multiplier and the output divider from its inputs. It then moves the control word through a fixed order: first it steers the output onto the bypass path and gates it, then it powers the loop down and latches the new dividers. After that it powers the loop up, waits a settling time, and polls the PLL lock signal for a bounded number of samples. Last, it re-enables the output and leaves bypass.

A sequence always runs to the end. If lock never arrives within the polling window, the sequencer raises a sticky timeout flag and still finishes the steps. The flag stays set until the next accepted start. The block also offers a combinational helper that works out the nominal output frequency in kHz from the divider fields now held in the control word. The analog PLL is not part of the block: the lock input comes from outside.

Top module: `pll_reprog_seq`

## Requirements
- R1: While reset is held and just after it is released, the control word is all zeros and busy, done and timeout are low.
- R2: Field placement in the control word: output divider in bits 6:0, feedback multiplier in bits 29:21, reference divider in bits 38:32, output-select in bit 40, parameter-latch in bit 43, bypass in bit 44, power-down in bit 45. Every other bit, including bit 39 (owned by the PLL for lock status), is driven 0.
- R3: A start pulse seen while idle captures the three divider inputs at that edge. On the next seven consecutive edges the block then: sets bypass; clears output-select; sets power-down; sets parameter-latch; writes the three divider fields; clears parameter-latch; clears power-down. Each of these steps changes only its own field.
- R4: After the power-up edge, the block lets exactly SETTLE_CYC clock cycles pass before it takes the first lock sample. SETTLE_CYC is SETTLE_NS at CLK_KHZ, rounded up, which is 500 cycles with the defaults.
- R5: The lock input is sampled once per cycle for at most POLL_LIMIT samples. On the first sample that is high, output-select is set on the next edge and timeout stays low.
- R6: If all POLL_LIMIT samples are low, the timeout flag is set. Output-select is set on the edge after the last sample, and the sequence still completes.
- R7: Bypass is cleared on the edge after output-select is set. On that same edge done rises for exactly one cycle and busy falls. Busy is high from the edge after start until then.
- R8: The timeout flag holds its value while idle and is cleared on the edge that accepts the next start.
- R9: A start pulse or a change of the divider inputs while busy has no effect on the running sequence or on the divider values it writes.
- R10: The frequency output equals (REF_KHZ / ref divider) * multiplier / output divider, computed with integer division from the fields held in the control word. It is 0 when either divider field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that begins a reprogramming sequence |
| div_ref_i | input | 7 | New reference divider |
| loopc_i | input | 9 | New feedback multiplier |
| div_out_i | input | 7 | New output divider |
| lock_i | input | 1 | Lock indication from the PLL |
| ctl_o | output | 64 | PLL control word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the sequence completes |
| timeout_o | output | 1 | Last lock wait ended without lock |
| freq_khz_o | output | 32 | Nominal output frequency from the held dividers, kHz |

## Verification
The sequencer is driven with random divider triples and random relock delays, against a behavioural PLL whose lock drops while power-down is set. Directed runs add the cases that split the timing rules apart. Lock already present at the first sample isolates the settle count. Lock arriving on the very last allowed sample, compared with one cycle later, marks the exact edge of the polling window. A PLL that never relocks shows that the block continues after a timeout. A run after a timeout shows that the flag is cleared. A start pulse with fresh divider values injected mid-sequence shows that inputs arriving while busy are ignored. The frequency helper is checked at reset, where the dividers are zero, and after every run.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  localparam int CTL_W      = 64;
  localparam int DOUT_W     = 7;
  localparam int LOOP_W     = 9;
  localparam int DREF_W     = 7;
  localparam int DOUT_LSB   = 0;
  localparam int LOOP_LSB   = 21;
  localparam int DREF_LSB   = 32;
  localparam int LOCK_BIT   = 39;
  localparam int OUTSEL_BIT = 40;
  localparam int LATCH_BIT  = 43;
  localparam int BYP_BIT    = 44;
  localparam int PDN_BIT    = 45;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_BYP,
    ST_GATE,
    ST_PDN,
    ST_LATCH,
    ST_DIVW,
    ST_UNLATCH,
    ST_PUP,
    ST_SETTLE,
    ST_POLL,
    ST_OUTEN,
    ST_UNBYP
  } seq_state_e;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_BYP_SET,
    OP_OUT_CLR,
    OP_PDN_SET,
    OP_LATCH_SET,
    OP_DIV_WR,
    OP_LATCH_CLR,
    OP_PDN_CLR,
    OP_OUT_SET,
    OP_BYP_CLR
  } ctl_op_e;

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] cnt_o
);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_we;

  always_comb begin
    cnt_we = clr_i | en_i;
    cnt_d  = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i) begin
      cnt_d = cnt_q + WIDTH'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 500,
  parameter int POLL_LIMIT = 2000,
  parameter int CNT_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              lock_i,
  input  logic [DREF_W-1:0] dref_i,
  input  logic [LOOP_W-1:0] loop_i,
  input  logic [DOUT_W-1:0] dout_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              cnt_clr_o,
  output logic              cnt_en_o,
  output ctl_op_e           op_o,
  output logic [DREF_W-1:0] dref_o,
  output logic [LOOP_W-1:0] loop_o,
  output logic [DOUT_W-1:0] dout_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);

  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] POLL_LAST   = CNT_W'(POLL_LIMIT - 1);

  seq_state_e        state_q, state_d;
  logic              timeout_q, timeout_d;
  logic              done_q, done_d;
  logic              cap_en;
  logic [DREF_W-1:0] dref_q;
  logic [LOOP_W-1:0] loop_q;
  logic [DOUT_W-1:0] dout_q;

  always_comb begin
    state_d   = state_q;
    timeout_d = timeout_q;
    done_d    = 1'b0;
    cap_en    = 1'b0;
    op_o      = OP_NONE;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d   = ST_BYP;
          cap_en    = 1'b1;
          timeout_d = 1'b0;
        end
      end
      ST_BYP: begin
        op_o    = OP_BYP_SET;
        state_d = ST_GATE;
      end
      ST_GATE: begin
        op_o    = OP_OUT_CLR;
        state_d = ST_PDN;
      end
      ST_PDN: begin
        op_o    = OP_PDN_SET;
        state_d = ST_LATCH;
      end
      ST_LATCH: begin
        op_o    = OP_LATCH_SET;
        state_d = ST_DIVW;
      end
      ST_DIVW: begin
        op_o    = OP_DIV_WR;
        state_d = ST_UNLATCH;
      end
      ST_UNLATCH: begin
        op_o    = OP_LATCH_CLR;
        state_d = ST_PUP;
      end
      ST_PUP: begin
        op_o    = OP_PDN_CLR;
        state_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (cnt_i == SETTLE_LAST) begin
          state_d = ST_POLL;
        end
      end
      ST_POLL: begin
        if (lock_i) begin
          state_d = ST_OUTEN;
        end else if (cnt_i == POLL_LAST) begin
          state_d   = ST_OUTEN;
          timeout_d = 1'b1;
        end
      end
      ST_OUTEN: begin
        op_o    = OP_OUT_SET;
        state_d = ST_UNBYP;
      end
      ST_UNBYP: begin
        op_o    = OP_BYP_CLR;
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cnt_clr_o = (state_d != state_q);
  assign cnt_en_o  = (state_q == ST_SETTLE) || (state_q == ST_POLL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      timeout_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      timeout_q <= timeout_d;
      done_q    <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dref_q <= '0;
      loop_q <= '0;
      dout_q <= '0;
    end else if (cap_en) begin
      dref_q <= dref_i;
      loop_q <= loop_i;
      dout_q <= dout_i;
    end
  end

  assign dref_o    = dref_q;
  assign loop_o    = loop_q;
  assign dout_o    = dout_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = timeout_q;

  // R4
  settle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE) ##1 (state_q == ST_POLL) |-> ($past(cnt_i) == SETTLE_LAST));

  // R5
  lock_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POLL && lock_i) |=> (state_q == ST_OUTEN && !timeout_q));

  // R6
  timeout_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_q) |-> (state_q == ST_OUTEN && !$past(lock_i)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8
  timeout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_i) |=> !timeout_q);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(dref_q) && $stable(loop_q) && $stable(dout_q)));

endmodule

// File: rtl/pll_ctl_image.sv
module pll_ctl_image
  import pll_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_op_e           op_i,
  input  logic [DREF_W-1:0] dref_i,
  input  logic [LOOP_W-1:0] loop_i,
  input  logic [DOUT_W-1:0] dout_i,
  output logic [CTL_W-1:0]  ctl_o
);

  logic [DREF_W-1:0] dref_q, dref_d;
  logic [LOOP_W-1:0] loop_q, loop_d;
  logic [DOUT_W-1:0] dout_q, dout_d;
  logic              outsel_q, outsel_d;
  logic              latch_q, latch_d;
  logic              byp_q, byp_d;
  logic              pdn_q, pdn_d;
  logic              img_we;

  always_comb begin
    dref_d   = dref_q;
    loop_d   = loop_q;
    dout_d   = dout_q;
    outsel_d = outsel_q;
    latch_d  = latch_q;
    byp_d    = byp_q;
    pdn_d    = pdn_q;
    img_we   = (op_i != OP_NONE);
    unique case (op_i)
      OP_BYP_SET:   byp_d    = 1'b1;
      OP_OUT_CLR:   outsel_d = 1'b0;
      OP_PDN_SET:   pdn_d    = 1'b1;
      OP_LATCH_SET: latch_d  = 1'b1;
      OP_DIV_WR: begin
        dref_d = dref_i;
        loop_d = loop_i;
        dout_d = dout_i;
      end
      OP_LATCH_CLR: latch_d  = 1'b0;
      OP_PDN_CLR:   pdn_d    = 1'b0;
      OP_OUT_SET:   outsel_d = 1'b1;
      OP_BYP_CLR:   byp_d    = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dref_q   <= '0;
      loop_q   <= '0;
      dout_q   <= '0;
      outsel_q <= 1'b0;
      latch_q  <= 1'b0;
      byp_q    <= 1'b0;
      pdn_q    <= 1'b0;
    end else if (img_we) begin
      dref_q   <= dref_d;
      loop_q   <= loop_d;
      dout_q   <= dout_d;
      outsel_q <= outsel_d;
      latch_q  <= latch_d;
      byp_q    <= byp_d;
      pdn_q    <= pdn_d;
    end
  end

  always_comb begin
    ctl_o = '0;
    ctl_o[DOUT_LSB +: DOUT_W] = dout_q;
    ctl_o[LOOP_LSB +: LOOP_W] = loop_q;
    ctl_o[DREF_LSB +: DREF_W] = dref_q;
    ctl_o[OUTSEL_BIT]         = outsel_q;
    ctl_o[LATCH_BIT]          = latch_q;
    ctl_o[BYP_BIT]            = byp_q;
    ctl_o[PDN_BIT]            = pdn_q;
  end

  // R3
  one_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ (dref_q != $past(dref_q)) || (loop_q != $past(loop_q)) || (dout_q != $past(dout_q)),
                 outsel_q != $past(outsel_q),
                 latch_q  != $past(latch_q),
                 byp_q    != $past(byp_q),
                 pdn_q    != $past(pdn_q) }) <= 1);

  // R3
  latch_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_q) |-> (pdn_q && byp_q && !outsel_q));

endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
  import pll_seq_pkg::*;
#(
  parameter int REF_KHZ = 100000,
  parameter int FREQ_W  = 32
) (
  input  logic [DREF_W-1:0] dref_i,
  input  logic [LOOP_W-1:0] loop_i,
  input  logic [DOUT_W-1:0] dout_i,
  output logic [FREQ_W-1:0] freq_o
);

  logic [FREQ_W-1:0] per_ref;
  logic [FREQ_W-1:0] vco;

  always_comb begin
    per_ref = '0;
    vco     = '0;
    freq_o  = '0;
    if ((dref_i != '0) && (dout_i != '0)) begin
      per_ref = FREQ_W'(REF_KHZ) / FREQ_W'(dref_i);
      vco     = per_ref * FREQ_W'(loop_i);
      freq_o  = vco / FREQ_W'(dout_i);
    end
  end

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int CLK_KHZ    = 250000,
  parameter int SETTLE_NS  = 2000,
  parameter int POLL_LIMIT = 2000,
  parameter int REF_KHZ    = 100000,
  parameter int FREQ_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [6:0]        div_ref_i,
  input  logic [8:0]        loopc_i,
  input  logic [6:0]        div_out_i,
  input  logic              lock_i,
  output logic [63:0]       ctl_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic [FREQ_W-1:0] freq_khz_o
);

  localparam longint SETTLE_RAW =
    (longint'(CLK_KHZ) * longint'(SETTLE_NS) + 64'sd999999) / 64'sd1000000;
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : int'(SETTLE_RAW);
  localparam int MAX_WAIT   = (SETTLE_CYC > POLL_LIMIT) ? SETTLE_CYC : POLL_LIMIT;
  localparam int CNT_W      = $clog2(MAX_WAIT + 1);
  localparam logic [CTL_W-1:0] USED_MASK =
      (CTL_W'((1 << DOUT_W) - 1) << DOUT_LSB)
    | (CTL_W'((1 << LOOP_W) - 1) << LOOP_LSB)
    | (CTL_W'((1 << DREF_W) - 1) << DREF_LSB)
    | (CTL_W'(1) << OUTSEL_BIT)
    | (CTL_W'(1) << LATCH_BIT)
    | (CTL_W'(1) << BYP_BIT)
    | (CTL_W'(1) << PDN_BIT);

  logic              cnt_clr;
  logic              cnt_en;
  logic [CNT_W-1:0]  cnt;
  ctl_op_e           op;
  logic [DREF_W-1:0] hold_dref;
  logic [LOOP_W-1:0] hold_loop;
  logic [DOUT_W-1:0] hold_dout;
  logic [CTL_W-1:0]  ctl;

  pll_seq_timer #(
    .WIDTH (CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cnt_clr),
    .en_i  (cnt_en),
    .cnt_o (cnt)
  );

  pll_seq_fsm #(
    .SETTLE_CYC (SETTLE_CYC),
    .POLL_LIMIT (POLL_LIMIT),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .lock_i    (lock_i),
    .dref_i    (div_ref_i),
    .loop_i    (loopc_i),
    .dout_i    (div_out_i),
    .cnt_i     (cnt),
    .cnt_clr_o (cnt_clr),
    .cnt_en_o  (cnt_en),
    .op_o      (op),
    .dref_o    (hold_dref),
    .loop_o    (hold_loop),
    .dout_o    (hold_dout),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .timeout_o (timeout_o)
  );

  pll_ctl_image u_image (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_i   (op),
    .dref_i (hold_dref),
    .loop_i (hold_loop),
    .dout_i (hold_dout),
    .ctl_o  (ctl)
  );

  pll_freq_calc #(
    .REF_KHZ (REF_KHZ),
    .FREQ_W  (FREQ_W)
  ) u_freq (
    .dref_i (ctl[DREF_LSB +: DREF_W]),
    .loop_i (ctl[LOOP_LSB +: LOOP_W]),
    .dout_i (ctl[DOUT_LSB +: DOUT_W]),
    .freq_o (freq_khz_o)
  );

  assign ctl_o = ctl;

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl_o & ~USED_MASK) == '0));

  // R7
  done_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ctl_o[OUTSEL_BIT] && !ctl_o[BYP_BIT] && !ctl_o[PDN_BIT] && !busy_o));

  // R7
  unbyp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_o[BYP_BIT]) |-> $past(ctl_o[OUTSEL_BIT]));

endmodule

// File: tb/pll_reprog_seq_tb.sv
`timescale 1ns/1ps
module pll_reprog_seq_tb;

  localparam int S_CYC = 500;   // 2 us at 250 MHz
  localparam int P_LIM = 2000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [6:0]  div_ref_i;
  logic [8:0]  loopc_i;
  logic [6:0]  div_out_i;
  logic        lock_i;
  logic [63:0] ctl_o;
  logic        busy_o, done_o, timeout_o;
  logic [31:0] freq_khz_o;

  int errs   = 0;
  int checks = 0;
  bit last_to = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pll_reprog_seq #(
    .CLK_KHZ    (250000),
    .SETTLE_NS  (2000),
    .POLL_LIMIT (P_LIM),
    .REF_KHZ    (100000),
    .FREQ_W     (32)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .div_ref_i  (div_ref_i),
    .loopc_i    (loopc_i),
    .div_out_i  (div_out_i),
    .lock_i     (lock_i),
    .ctl_o      (ctl_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .timeout_o  (timeout_o),
    .freq_khz_o (freq_khz_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic longint bench_freq(input int dr, input int lc, input int dv);
    if (dr == 0 || dv == 0) return 0;
    return longint'(((100000 / dr) * lc) / dv);
  endfunction

  function automatic logic [63:0] with_divs(input logic [63:0] img, input int dr,
                                            input int lc, input int dv);
    logic [63:0] r;
    r = img;
    r[6:0]   = 7'(dv);
    r[29:21] = 9'(lc);
    r[38:32] = 7'(dr);
    return r;
  endfunction

  // One full sequence; dly: cycles after power-up before model relocks.
  task automatic run_seq(input int dr, input int lc, input int dv, input int dly,
                         input bit dead, input int poke);
    logic [63:0] img;
    logic [63:0] fin;
    int rel, lcnt, lock_edge, first_poll, seen, sel_edge, exp_sel, exp_done;
    int sel_seen, done_seen;
    bit exp_to, done_low_chk;
    @(negedge clk);
    chk(timeout_o == last_to, "R8", "timeout held while idle", timeout_o, last_to);
    img = ctl_o;
    start_i   = 1'b1;
    div_ref_i = 7'(dr);
    loopc_i   = 9'(lc);
    div_out_i = 7'(dv);
    lcnt = 0; lock_edge = 0; sel_seen = -1; done_seen = -1; done_low_chk = 1'b0;
    first_poll = 8 + S_CYC;
    rel = -1;
    while (rel < first_poll + P_LIM + 20) begin
      @(negedge clk);
      rel++;
      start_i = 1'b0;
      if (rel == 0) begin
        // R3 dividers are captured at start; later input changes are irrelevant
        div_ref_i = 7'($urandom);
        loopc_i   = 9'($urandom);
        div_out_i = 7'($urandom);
        chk(busy_o == 1'b1, "R7", "busy after start", busy_o, 1);
        chk(timeout_o == 1'b0, "R8", "timeout cleared by start", timeout_o, 0);
      end
      if (poke >= 0 && rel == poke) begin
        start_i   = 1'b1;   // R9 start while busy
        div_ref_i = 7'($urandom);
        loopc_i   = 9'($urandom);
        div_out_i = 7'($urandom);
      end
      if (rel >= 1 && rel <= 7) begin
        case (rel)
          1: img[44] = 1'b1;
          2: img[40] = 1'b0;
          3: img[45] = 1'b1;
          4: img[43] = 1'b1;
          5: img = with_divs(img, dr, lc, dv);
          6: img[43] = 1'b0;
          default: img[45] = 1'b0;
        endcase
        chk(ctl_o == img, "R3", $sformatf("step %0d image", rel), ctl_o, img);
      end
      if (sel_seen < 0 && rel >= 2 && ctl_o[40]) sel_seen = rel;
      if (done_seen >= 0 && !done_low_chk) begin
        chk(done_o == 1'b0, "R7", "done one cycle", done_o, 0);
        done_low_chk = 1'b1;
        break;
      end
      if (done_seen < 0 && done_o) begin
        done_seen = rel;
        chk(busy_o == 1'b0, "R7", "busy low at done", busy_o, 0);
      end
      // behavioural PLL
      if (ctl_o[45]) begin
        lock_i = 1'b0;
        lcnt = 0;
      end else if (rel >= 7 && !dead && !lock_i) begin
        if (lcnt >= dly) begin
          lock_i = 1'b1;
          lock_edge = rel + 1;
        end else begin
          lcnt++;
        end
      end
    end
    seen = (lock_edge > first_poll) ? lock_edge : first_poll;
    if (!dead && seen <= first_poll + P_LIM - 1) begin
      exp_sel = seen + 1; exp_to = 1'b0;
    end else begin
      exp_sel = first_poll + P_LIM; exp_to = 1'b1;
    end
    exp_done = exp_sel + 1;
    chk(sel_seen == exp_sel, exp_to ? "R6" : "R5", "output-select edge", sel_seen, exp_sel);
    chk(done_seen == exp_done, "R7", "done edge", done_seen, exp_done);
    chk(timeout_o == exp_to, exp_to ? "R6" : "R5", "timeout flag", timeout_o, exp_to);
    fin = with_divs(64'h0, dr, lc, dv);
    fin[40] = 1'b1;
    chk(ctl_o == fin, (poke >= 0) ? "R9" : "R2", "final image", ctl_o, fin);
    chk(longint'(freq_khz_o) == bench_freq(dr, lc, dv), "R10", "frequency",
        freq_khz_o, bench_freq(dr, lc, dv));
    last_to = exp_to;
  endtask

  initial begin
    int unsigned sd;
    sd = $urandom(32'd20240611);
    rst_n = 1'b0; start_i = 1'b0; lock_i = 1'b1;
    div_ref_i = '0; loopc_i = '0; div_out_i = '0;
    repeat (4) @(negedge clk);
    chk(ctl_o == 64'h0, "R1", "image in reset", ctl_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctl_o == 64'h0, "R1", "image after reset", ctl_o, 0);
    chk({busy_o, done_o, timeout_o} == 3'b000, "R1", "flags after reset",
        {busy_o, done_o, timeout_o}, 0);
    chk(freq_khz_o == 32'd0, "R10", "zero dividers give zero", freq_khz_o, 0);
    // directed corners
    run_seq(3, 49, 11, 0, 1'b0, -1);                 // R4 lock already present
    run_seq(5, 78, 11, S_CYC + P_LIM - 1, 1'b0, -1); // R5 lock on last sample
    run_seq(4, 58, 8, S_CYC + P_LIM, 1'b0, -1);      // R6 lock one cycle too late
    run_seq(3, 36, 30, 10, 1'b0, -1);                // R8 clears prior timeout
    run_seq(4, 95, 8, 0, 1'b1, -1);                  // R6 dead PLL
    run_seq(5, 107, 85, 40, 1'b0, 200);              // R9 start while busy
    run_seq(5, 151, 10, 3, 1'b0, 3);                 // R9 start during latch steps
    for (int i = 0; i < 8; i++) begin
      run_seq(1 + int'($urandom % 127), int'($urandom % 512), 1 + int'($urandom % 127),
              int'($urandom % (S_CYC + 120)), 1'b0, -1);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule